// File: doc/BRIEF.md
# Banked Interrupt Request Aggregator

This block gathers a set of interrupt request lines, organised as byte-wide banks (three banks of eight by default), into one registered request line for a host that triggers on rising edges. Each bank has a status register and a mask register. Both sit on a small byte-wide register port that decodes an address, a write strobe and a read strobe.

All request inputs but one pass through a two-flop synchronizer and are edge-sensitive. A rising edge on an input sets its status bit only if that input's mask bit is already 1 at that moment. Reading a bank's status register clears that bank's latched edge bits; there is no separate acknowledge. An edge that arrives while its input is masked is dropped for good, even if the input is later unmasked while it is still high.

The one level-sensitive input is chosen by a parameter. Its status bit follows the synchronized input level and is not cleared by reads. The host request is the registered OR of all bits whose status and mask are both 1. The register port uses this map:

- Addresses 0, 1 and 2 are the status registers of banks 0, 1 and 2.
- Addresses 3, 4 and 5 are the mask registers of banks 0, 1 and 2.
- Any other address reads as 0.

Top module: `irq_byte_agg`

## Requirements
- R1: Input index 8*b+k appears as bit k of status address b and is enabled by bit k of mask address 3+b, for banks b = 0, 1, 2.
- R2: Writing a mask address stores the byte. A mask bit of 1 enables its input and a 0 disables it. The stored mask reads back from the same address.
- R3: `host_irq` is the registered OR over all banks of (status AND mask). It changes on the clock edge after the status or mask change.
- R4: A rising edge on an enabled edge input sets its status bit. The bit is readable on the third rising clock edge after the input rises, and `host_irq` rises on the fourth.
- R5: A status read (`reg_rd`=1 at a status address) clears the latched edge bits of that bank only. Latched bits in the other banks keep their values.
- R6: An edge that arrives while its mask bit is 0 is not recorded. If that input is unmasked later while it is still high, its status stays 0 and no host request follows.
- R7: The level-sensitive input (index LEVEL_IDX, default 5) shows its synchronized level as its status bit whatever its mask. A read does not clear it.
- R8: After reset, all mask registers, all status bits and `host_irq` are 0.
- R9: When a new enabled edge and a status read of its bank fall on the same clock edge, the new edge is kept latched.
- R10: Writes to status addresses 0 to 2 change no state. Reads of addresses 6 and 7 return 0.
- R11: `host_irq` falls once no bit is pending, and rises again when a new pending bit arises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 24 | Raw interrupt request inputs |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; clears the addressed status bank on the clock edge |
| reg_rdata | output | 8 | Read data for the current address (combinational) |
| host_irq | output | 1 | Registered combined request to the host |

## Verification
On every cycle, the assertions check these rules:
- A masked edge bit never becomes set.
- A read with no new edge empties an edge bit.
- An enabled edge is always latched, even against a simultaneous read.
- `host_irq` follows the pending OR one cycle later.
- A write to a status address leaves the masks alone.

Some behaviour only the bench's scenarios can show:
- The exact latency from a raw input through the synchronizer.
- The lost-interrupt case where an input is unmasked while already high.
- The level bit surviving repeated reads.
- Bank isolation of read-to-clear.
- The host line falling and then rising again.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int BANK_W = 8;

  // next value of a latched edge vector: a read empties it, new hits always win
  function automatic logic [BANK_W-1:0] latch_next(
    input logic [BANK_W-1:0] cur,
    input logic              clr,
    input logic [BANK_W-1:0] hit
  );
    return (clr ? '0 : cur) | hit;
  endfunction

  // per-bank level-sensitive selection derived from a flat input index
  function automatic logic [BANK_W-1:0] level_sel(input int bank, input int lvl_idx);
    logic [BANK_W-1:0] v;
    v = '0;
    if ((lvl_idx / BANK_W) == bank) v[lvl_idx % BANK_W] = 1'b1;
    return v;
  endfunction

  // status shown to software: latched edges plus live level bits
  function automatic logic [BANK_W-1:0] status_view(
    input logic [BANK_W-1:0] latched,
    input logic [BANK_W-1:0] live,
    input logic [BANK_W-1:0] lvl
  );
    return (latched & ~lvl) | (live & lvl);
  endfunction
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter logic [BANK_W-1:0] LEVEL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] sync_in,
  input  logic              mask_we,
  input  logic [BANK_W-1:0] mask_wdata,
  input  logic              rd_clr,
  output logic [BANK_W-1:0] status_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] pend_o
);
  logic [BANK_W-1:0] prev_q, latch_q, mask_q;
  logic [BANK_W-1:0] edge_seen, edge_hit;

  assign edge_seen = sync_in & ~prev_q;
  assign edge_hit  = edge_seen & mask_q & ~LEVEL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
      mask_q  <= '0;
    end else begin
      prev_q  <= sync_in;
      latch_q <= latch_next(latch_q, rd_clr, edge_hit) & ~LEVEL_MASK;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign status_o = status_view(latch_q, sync_in, LEVEL_MASK);
  assign mask_o   = mask_q;
  assign pend_o   = status_o & mask_q;

  for (genvar i = 0; i < BANK_W; i++) begin : g_bit
    if (!LEVEL_MASK[i]) begin : g_edge
      // R6: a disabled input cannot set its latch
      assert_masked_edge_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[i] && !latch_q[i]) |=> !latch_q[i]);
      // R5: a read with no simultaneous hit empties the bit
      assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !edge_hit[i]) |=> !latch_q[i]);
      // R9: an enabled edge is latched even against a read
      assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit[i] |=> latch_q[i]);
    end
  end
endmodule

// File: rtl/irq_byte_agg.sv
module irq_byte_agg
  import irqagg_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int LEVEL_IDX   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_wr,
  input  logic [BANK_W-1:0]           reg_wdata,
  input  logic                        reg_rd,
  output logic [BANK_W-1:0]           reg_rdata,
  output logic                        host_irq
);
  localparam int NIN = NUM_BANKS * BANK_W;

  logic [NIN-1:0]    irq_s;
  logic [NIN-1:0]    status_all, mask_all, pend_all;
  logic [NUM_BANKS-1:0] rd_clr, mask_we;
  logic              pend_any;
  logic              host_q;

  irqagg_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(irq_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign rd_clr[b]  = reg_rd && (int'(reg_addr) == b);
    assign mask_we[b] = reg_wr && (int'(reg_addr) == NUM_BANKS + b);

    irqagg_bank #(.LEVEL_MASK(level_sel(b, LEVEL_IDX))) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (irq_s[b*BANK_W +: BANK_W]),
      .mask_we   (mask_we[b]),
      .mask_wdata(reg_wdata),
      .rd_clr    (rd_clr[b]),
      .status_o  (status_all[b*BANK_W +: BANK_W]),
      .mask_o    (mask_all[b*BANK_W +: BANK_W]),
      .pend_o    (pend_all[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(reg_addr) == b)             reg_rdata = status_all[b*BANK_W +: BANK_W];
      if (int'(reg_addr) == NUM_BANKS + b) reg_rdata = mask_all[b*BANK_W +: BANK_W];
    end
  end

  assign pend_any = |pend_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_q <= 1'b0;
    else        host_q <= pend_any;
  end

  assign host_irq = host_q;

  // R3: output tracks the pending OR one cycle later
  assert_host_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |=> host_irq);
  assert_host_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_any |=> !host_irq);
  // R10: writes to status addresses leave every mask untouched
  assert_status_wr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (int'(reg_addr) < NUM_BANKS)) |=> $stable(mask_all));
endmodule

// File: tb/sim_irq_byte_agg.sv
`timescale 1ns/1ps
module sim_irq_byte_agg;
  localparam int NIN = 24;
  localparam logic [NIN-1:0] LVL = 24'h000020;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NIN-1:0] irq_in = '0;
  logic [2:0]     reg_addr = '0;
  logic           reg_wr = 1'b0;
  logic [7:0]     reg_wdata = '0;
  logic           reg_rd = 1'b0;
  logic [7:0]     reg_rdata;
  logic           host_irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_byte_agg u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  // {pattern, mask}
  localparam logic [47:0] VEC [7] = '{
    {24'h000001, 24'h000001},
    {24'h0F0F0F, 24'h00FF00},
    {24'h000020, 24'h000000},
    {24'h000020, 24'h000020},
    {24'hFFFFFF, 24'hFFFFFF},
    {24'h800000, 24'h7FFFFF},
    {24'h000000, 24'hFFFFFF}
  };

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_masks(input logic [23:0] m);
    wr(3'd3, m[7:0]); wr(3'd4, m[15:8]); wr(3'd5, m[23:16]);
  endtask

  task automatic drain();
    logic [7:0] t;
    irq_in = '0;
    repeat (5) @(posedge clk);
    rd(3'd0, t); rd(3'd1, t); rd(3'd2, t);
  endtask

  task automatic wait_host();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d0, d1, d2;
    logic [23:0] exp;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8 reset state
    check("R8 host", {23'd0, host_irq}, 24'd0);
    peek(3'd3, d0); peek(3'd4, d1); peek(3'd5, d2);
    check("R8 masks", {d2, d1, d0}, 24'd0);
    peek(3'd0, d0); peek(3'd1, d1); peek(3'd2, d2);
    check("R8 status", {d2, d1, d0}, 24'd0);

    // vector table: R1 R2 R3 R4 R7
    for (int v = 0; v < 7; v++) begin
      logic [23:0] pat, msk;
      pat = VEC[v][47:24];
      msk = VEC[v][23:0];
      drain();
      set_masks(msk);
      peek(3'd3, d0); peek(3'd4, d1); peek(3'd5, d2);
      check("R2 mask readback", {d2, d1, d0}, msk);
      @(negedge clk) irq_in = pat;
      wait_host();
      exp = (pat & msk & ~LVL) | (pat & LVL);
      check("R3 R4 host", {23'd0, host_irq}, {23'd0, |(exp & msk)});
      rd(3'd0, d0); rd(3'd1, d1); rd(3'd2, d2);
      check("R1 R4 R7 status", {d2, d1, d0}, exp);
    end

    // R4 latency: status visible after 3rd edge, host after 4th
    drain();
    set_masks(24'h000100);
    @(negedge clk) irq_in = 24'h000100;
    repeat (2) @(posedge clk);
    @(negedge clk) reg_addr = 3'd1;
    #1 check("R4 not yet latched", {16'd0, reg_rdata}, 24'h0);
    @(posedge clk); @(negedge clk);
    #1 check("R4 latched at third edge", {16'd0, reg_rdata}, 24'h01);
    check("R4 host not yet", {23'd0, host_irq}, 24'd0);
    @(posedge clk); @(negedge clk);
    check("R4 host at fourth edge", {23'd0, host_irq}, 24'd1);

    // R5 read clears only its own bank
    drain();
    set_masks(24'h010100);
    @(negedge clk) irq_in = 24'h010100;
    wait_host();
    rd(3'd1, d1);
    check("R5 first read", {16'd0, d1}, 24'h01);
    rd(3'd1, d1);
    check("R5 cleared", {16'd0, d1}, 24'h00);
    rd(3'd2, d2);
    check("R5 other bank kept", {16'd0, d2}, 24'h01);

    // R6 masked edge is lost even if unmasked while high
    drain();
    set_masks(24'h0);
    @(negedge clk) irq_in = 24'h000004;
    wait_host();
    set_masks(24'h000004);
    wait_host();
    check("R6 host", {23'd0, host_irq}, 24'd0);
    rd(3'd0, d0);
    check("R6 status", {16'd0, d0}, 24'h00);

    // R7 level bit not cleared by reads; R11 fall and re-rise
    drain();
    set_masks(24'h000020);
    @(negedge clk) irq_in = 24'h000020;
    wait_host();
    rd(3'd0, d0); rd(3'd0, d0);
    check("R7 level survives reads", {16'd0, d0}, 24'h20);
    check("R7 host", {23'd0, host_irq}, 24'd1);
    @(negedge clk) irq_in = 24'h0;
    wait_host();
    check("R11 host fell", {23'd0, host_irq}, 24'd0);
    rd(3'd0, d0);
    check("R7 level follows low", {16'd0, d0}, 24'h00);
    @(negedge clk) irq_in = 24'h000020;
    wait_host();
    check("R11 host rose again", {23'd0, host_irq}, 24'd1);

    // R9 edge coinciding with a read of its bank
    drain();
    set_masks(24'h000003);
    @(negedge clk) irq_in = 24'h000002;
    wait_host();
    @(negedge clk) irq_in = 24'h000003;
    repeat (2) @(posedge clk);
    @(negedge clk) begin reg_addr = 3'd0; reg_rd = 1'b1; end
    #1 check("R9 read before edge", {16'd0, reg_rdata}, 24'h02);
    @(negedge clk) reg_rd = 1'b0;
    rd(3'd0, d0);
    check("R9 edge kept", {16'd0, d0}, 24'h01);

    // R10 status writes ignored, unused addresses read 0
    drain();
    set_masks(24'h00A500);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFF);
    peek(3'd1, d1);
    check("R10 status write ignored", {16'd0, d1}, 24'h00);
    peek(3'd4, d1);
    check("R10 mask unchanged", {16'd0, d1}, 24'hA5);
    peek(3'd6, d0); peek(3'd7, d2);
    check("R10 unused reads", {8'd0, d2, d0}, 24'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule